// File: doc/BRIEF.md
# ADC Conversion Slot Sequencer

This block sits in front of the control core of a 12-bit successive-approximation converter and decides which channel gets converted next. The order of conversions comes from a slot table fixed at elaboration time. The table holds 1 to 64 entries, and each entry names a 5-bit channel. A channel may appear in several entries so that it is sampled more often. The sequencer offers each slot on a valid/ready command stream. It flags the first slot of a pass with a start marker and the last slot with an end marker.

Results come back on a response stream that carries the channel and 12-bit unipolar data. The block registers each result once and tags it with the same start and end markers, which it derives from its own count of returned results. A small control register has a run bit and a continuous bit. A single pass clears the run bit itself once the last result is in. A continuous pass keeps wrapping until software clears the run bit, and then it finishes the pass already under way.

One channel number is the on-die temperature sensor, which converts at a slower rate. Whenever the next slot needs a rate other than the one the converter is set to, the block holds off the command for a recalibration gap of a fixed number of conversion periods at the new rate.

Top module: `adc_slot_sequencer`

## Requirements
- R1: After reset the command valid, response valid and run outputs are 0, the slot position is 0 (command start marker high), and no command is offered while the run bit stays 0.
- R2: The command channel equals the table entry at the current slot (slot i at bits [i*5+4:i*5] of the table). The slot advances only on a cycle with valid and ready both high, and it wraps to slot 0 after the last slot. While ready is held low the same slot stays offered.
- R3: The command start marker is high exactly for slot 0, and the end marker is high exactly for the last slot.
- R4: Each response input appears on the response outputs one clock later with the same channel and data. The k-th response since reset (counting from 0) carries the start marker when k mod NUM_SLOTS is 0 and the end marker when k mod NUM_SLOTS is NUM_SLOTS-1.
- R5: With the continuous bit 0, writing run=1 issues exactly NUM_SLOTS commands. The run bit reads 0 in the same cycle the end-marked response is presented, and no further command is offered.
- R6: With the continuous bit 1 and run=1, the sequencer wraps and keeps issuing passes without any gap between them.
- R7: Clearing the run bit in continuous mode lets the current pass finish through its end-marked slot, and then command valid stays 0.
- R8: When a slot's rate class (temperature channel or normal) differs from the converter's current class, command valid stays low for CAL_PERIODS*P+1 clocks after the previous handshake. P is SLOW_PERIOD for a temperature slot and FAST_PERIOD for a normal slot. The converter starts in the normal class.
- R9: Between consecutive slots of the same class within a pass, command valid is high in the cycle right after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_run_in | input | 1 | Run bit to write |
| ctl_cont_in | input | 1 | Continuous bit to write |
| ctl_run | output | 1 | Current run bit |
| ctl_cont | output | 1 | Current continuous bit |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Control core accepts command |
| cmd_ch | output | CH_W | Channel to convert |
| cmd_sop | output | 1 | First slot of pass |
| cmd_eop | output | 1 | Last slot of pass |
| rsp_valid_in | input | 1 | Result from control core |
| rsp_ch_in | input | CH_W | Result channel |
| rsp_data_in | input | DATA_W | Result data |
| rsp_valid | output | 1 | Forwarded result valid |
| rsp_ch | output | CH_W | Forwarded channel |
| rsp_data | output | DATA_W | Forwarded data |
| rsp_sop | output | 1 | Result belongs to slot 0 |
| rsp_eop | output | 1 | Result belongs to last slot |

## Verification
The bench builds the sequencer with six slots: channel 3 twice, then the temperature channel (17) twice, then channels 9 and 0. It sets FAST_PERIOD to 3 and SLOW_PERIOD to 8, so the two recalibration gaps last 19 and 49 clocks. Both class switches and a same-class wrap happen within every pass, along with a repeated channel on each side of a switch. The short periods let many passes, including a stop requested in the middle of a pass, run in a few thousand clocks under random ready and response timing.

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer #(
  parameter int NUM_SLOTS   = 8,
  parameter int CH_W        = 5,
  parameter int DATA_W      = 12,
  parameter int TEMP_CH     = 17,
  parameter int FAST_PERIOD = 10,
  parameter int SLOW_PERIOD = 200,
  parameter int CAL_PERIODS = 6,
  parameter logic [NUM_SLOTS*CH_W-1:0] SLOT_TABLE =
    {5'd0, 5'd17, 5'd3, 5'd1, 5'd2, 5'd17, 5'd1, 5'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_run_in,
  input  logic              ctl_cont_in,
  output logic              ctl_run,
  output logic              ctl_cont,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CH_W-1:0]   cmd_ch,
  output logic              cmd_sop,
  output logic              cmd_eop,
  input  logic              rsp_valid_in,
  input  logic [CH_W-1:0]   rsp_ch_in,
  input  logic [DATA_W-1:0] rsp_data_in,
  output logic              rsp_valid,
  output logic [CH_W-1:0]   rsp_ch,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_sop,
  output logic              rsp_eop
);
  localparam int PTR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int LAST     = NUM_SLOTS - 1;
  localparam int FAST_GAP = CAL_PERIODS * FAST_PERIOD;
  localparam int SLOW_GAP = CAL_PERIODS * SLOW_PERIOD;
  localparam int MAX_GAP  = (SLOW_GAP > FAST_GAP) ? SLOW_GAP : FAST_GAP;
  localparam int CNT_W    = $clog2(MAX_GAP + 1);

  logic [PTR_W-1:0] ptr, rptr;
  logic             wait_q, cur_temp;
  logic [CNT_W-1:0] cal_cnt;

  wire [CH_W-1:0] slot_ch   = SLOT_TABLE[ptr*CH_W +: CH_W];
  wire            slot_temp = (slot_ch == CH_W'(TEMP_CH));
  wire            last_slot = (ptr == PTR_W'(LAST));
  wire            rsp_last  = (rptr == PTR_W'(LAST));
  wire            go        = (ptr != '0) || (ctl_run && !wait_q);
  wire            hs        = cmd_valid && cmd_ready;

  assign cmd_valid = go && (cal_cnt == '0) && (slot_temp == cur_temp);
  assign cmd_ch    = slot_ch;
  assign cmd_sop   = (ptr == '0);
  assign cmd_eop   = last_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      cur_temp <= 1'b0;
      cal_cnt  <= '0;
    end else begin
      if (hs) ptr <= last_slot ? '0 : ptr + 1'b1;
      if (cal_cnt != '0) cal_cnt <= cal_cnt - 1'b1;
      else if (go && slot_temp != cur_temp) begin
        cur_temp <= slot_temp;
        cal_cnt  <= slot_temp ? CNT_W'(SLOW_GAP) : CNT_W'(FAST_GAP);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_run  <= 1'b0;
      ctl_cont <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_run  <= ctl_run_in;
        ctl_cont <= ctl_cont_in;
      end else if (rsp_valid_in && rsp_last && !ctl_cont) ctl_run <= 1'b0;
      if (hs && last_slot && !ctl_cont) wait_q <= 1'b1;
      else if (rsp_valid_in && rsp_last) wait_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr      <= '0;
      rsp_valid <= 1'b0;
      rsp_ch    <= '0;
      rsp_data  <= '0;
      rsp_sop   <= 1'b0;
      rsp_eop   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_in;
      if (rsp_valid_in) begin
        rsp_ch   <= rsp_ch_in;
        rsp_data <= rsp_data_in;
        rsp_sop  <= (rptr == '0);
        rsp_eop  <= rsp_last;
        rptr     <= rsp_last ? '0 : rptr + 1'b1;
      end
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> $stable(ptr)); // R2
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_eop |=> cmd_sop); // R3
  AST_GAP_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    cur_temp != $past(cur_temp) |-> !cmd_valid); // R8
  AST_RSP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_in |=> rsp_valid && rsp_ch == $past(rsp_ch_in) && rsp_data == $past(rsp_data_in)); // R4
  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_eop && !ctl_cont && !$past(ctl_wr) |-> !ctl_run); // R5
  AST_STOP_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_eop && !ctl_run && !ctl_wr |=> !cmd_valid); // R7
endmodule

// File: tb/sim_adc_slot_sequencer.sv
`timescale 1ns/1ps
module sim_adc_slot_sequencer;
  localparam int N = 6, CHW = 5, DW = 12, TEMP = 17, FP = 3, SP = 8, CAL = 6;
  localparam logic [N*CHW-1:0] TABLE = {5'd0, 5'd9, 5'd17, 5'd17, 5'd3, 5'd3};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_run_in = 0, ctl_cont_in = 0, ctl_run, ctl_cont;
  logic cmd_valid, cmd_ready = 0, cmd_sop, cmd_eop;
  logic [CHW-1:0] cmd_ch, rsp_ch, rsp_ch_in = '0;
  logic rsp_valid_in = 0, rsp_valid, rsp_sop, rsp_eop;
  logic [DW-1:0] rsp_data_in = '0, rsp_data;

  always #2.5 clk = ~clk;

  adc_slot_sequencer #(.NUM_SLOTS(N), .CH_W(CHW), .DATA_W(DW), .TEMP_CH(TEMP),
    .FAST_PERIOD(FP), .SLOW_PERIOD(SP), .CAL_PERIODS(CAL), .SLOT_TABLE(TABLE)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run_in(ctl_run_in),
    .ctl_cont_in(ctl_cont_in), .ctl_run(ctl_run), .ctl_cont(ctl_cont),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ch(cmd_ch), .cmd_sop(cmd_sop),
    .cmd_eop(cmd_eop), .rsp_valid_in(rsp_valid_in), .rsp_ch_in(rsp_ch_in),
    .rsp_data_in(rsp_data_in), .rsp_valid(rsp_valid), .rsp_ch(rsp_ch),
    .rsp_data(rsp_data), .rsp_sop(rsp_sop), .rsp_eop(rsp_eop));

  int total = 0, bad = 0, hs_cnt = 0;
  bit done = 0, hold_ready = 0, single_mode = 0;
  int pend[$];
  bit drv_v = 0;
  int drv_ch = 0, drv_d = 0, drv_k = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slot_ch(int s);
    return int'((TABLE >> (s * CHW)) & 30'h1f);
  endfunction
  function automatic int gap_of(int ch);
    return (ch == TEMP ? SP : FP) * CAL + 1;
  endfunction
  function automatic int rdata(int ch, int k);
    return (ch * 97 + k * 13 + 5) & 12'hfff;
  endfunction

  initial begin
    int exp_ptr = 0, low_cnt = 0, prev_temp = 0, rsp_k = 0, t = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      chk(rsp_valid == drv_v, "R4 valid", rsp_valid, drv_v);
      if (drv_v) begin
        chk(int'(rsp_ch) == drv_ch, "R4 ch", rsp_ch, drv_ch);
        chk(int'(rsp_data) == drv_d, "R4 data", rsp_data, drv_d);
        chk(rsp_sop == (drv_k % N == 0), "R4 sop", rsp_sop, drv_k % N == 0);
        chk(rsp_eop == (drv_k % N == N - 1), "R4 eop", rsp_eop, drv_k % N == N - 1);
        if (rsp_eop && single_mode) chk(ctl_run == 0, "R5 run clear", ctl_run, 0);
      end
      drv_v = 0;
      if (pend.size() > 0 && ($urandom % 3) == 0) begin
        drv_ch = pend.pop_front();
        drv_k = rsp_k;
        drv_d = rdata(drv_ch, rsp_k);
        rsp_k++;
        drv_v = 1;
      end
      rsp_valid_in = drv_v;
      rsp_ch_in = drv_ch[CHW-1:0];
      rsp_data_in = drv_d[DW-1:0];
      cmd_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
      if (cmd_valid && cmd_ready) begin
        chk(int'(cmd_ch) == slot_ch(exp_ptr), "R2 ch", cmd_ch, slot_ch(exp_ptr));
        chk(cmd_sop == (exp_ptr == 0), "R3 sop", cmd_sop, exp_ptr == 0);
        chk(cmd_eop == (exp_ptr == N - 1), "R3 eop", cmd_eop, exp_ptr == N - 1);
        t = (slot_ch(exp_ptr) == TEMP) ? 1 : 0;
        if (exp_ptr != 0) begin
          if (t != prev_temp) chk(low_cnt == gap_of(slot_ch(exp_ptr)), "R8 gap", low_cnt, gap_of(slot_ch(exp_ptr)));
          else chk(low_cnt == 0, "R9 no gap", low_cnt, 0);
        end
        prev_temp = t;
        pend.push_back(int'(cmd_ch));
        hs_cnt++;
        exp_ptr = (exp_ptr + 1) % N;
        low_cnt = 0;
      end else if (!cmd_valid) low_cnt++;
    end
  end

  task automatic write_ctl(bit run, bit cont);
    @(negedge clk);
    ctl_wr = 1; ctl_run_in = run; ctl_cont_in = cont;
    single_mode = !cont;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && (pend.size() > 0 || drv_v); i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int base;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(ctl_run == 0, "R1 run", ctl_run, 0);
    chk(cmd_sop == 1, "R1 slot0", cmd_sop, 1);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(hs_cnt == 0, "R1 idle", hs_cnt, 0);

    hold_ready = 1;
    write_ctl(1, 0);
    repeat (30) @(negedge clk);
    chk(cmd_valid == 1, "R2 hold valid", cmd_valid, 1);
    chk(int'(cmd_ch) == slot_ch(0), "R2 hold ch", cmd_ch, slot_ch(0));
    chk(hs_cnt == 0, "R2 no advance", hs_cnt, 0);
    hold_ready = 0;
    for (int i = 0; i < 20000 && ctl_run; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(hs_cnt == N, "R5 count", hs_cnt, N);
    chk(cmd_valid == 0, "R5 idle", cmd_valid, 0);
    drain();

    base = hs_cnt;
    write_ctl(1, 1);
    for (int i = 0; i < 50000 && hs_cnt < base + 3 * N + 2; i++) @(negedge clk);
    chk(ctl_run == 1, "R6 run held", ctl_run, 1);
    write_ctl(0, 1);
    repeat (500) @(negedge clk);
    chk(hs_cnt - base > N, "R6 wrap", hs_cnt - base, 4 * N);
    chk(hs_cnt - base == 4 * N, "R7 finish pass", hs_cnt - base, 4 * N);
    chk(cmd_valid == 0, "R7 stopped", cmd_valid, 0);
    drain();

    base = hs_cnt;
    write_ctl(1, 0);
    for (int i = 0; i < 20000 && ctl_run; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(hs_cnt - base == N, "R5 second", hs_cnt - base, N);
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule